// File: doc/BRIEF.md
# Presence-Tagged Word Memory

This block is a small synchronous memory in which each stored word has a one-bit presence tag. The tag shows whether the word holds a value that has not been consumed yet (full) or has no such value (empty). A producer port deposits a word only into an empty slot. A consumer port takes a word only out of a full slot. The tag changes in the same clock edge as the data transfer, so no other access can see a word whose data and tag disagree. Producer and consumer threads can therefore hand over single words without a separate lock.

Each port has a request, an address and a mode bit. In synchronising mode the access depends on the tag. In raw mode the tag is ignored, which is used to preload or inspect the memory. Both ports answer in the cycle of the request with either a done or a retry strobe. Read data appears one cycle after an accepted read. When both ports address the same word in one cycle, the read is resolved first. A full word can therefore be drained and refilled in a single cycle.

Top module: `fe_word_mem`

## Requirements
- R1: A raw-mode write (`wr_sync`=0) always completes, stores `wr_data` at `wr_addr`, and marks the word full, whatever its previous tag.
- R2: A synchronising write (`wr_sync`=1) to an empty word raises `wr_done` in the same cycle, stores the data and marks the word full.
- R3: A synchronising write to a full word raises `wr_retry` in the same cycle and changes neither the stored data nor the tag.
- R4: A synchronising read (`rd_sync`=1) of a full word raises `rd_done` in the same cycle, returns the stored word on `rd_data` with `rd_valid` high one cycle later, and marks the word empty.
- R5: A synchronising read of an empty word raises `rd_retry` in the same cycle, produces no `rd_valid` in the next cycle and leaves the tag empty.
- R6: When both ports access the same word in one cycle, the read is evaluated against the tag before the write. A full word is returned with its old data and is then refilled by a synchronising write. On an empty word the synchronising read retries and the write completes.
- R7: A raw-mode read (`rd_sync`=0) always completes, returns the stored word one cycle later, and leaves the tag unchanged.
- R8: Reset (`rst_n`=0, asynchronous) empties every word and clears `rd_valid`.
- R9: While a port requests, exactly one of its done and retry strobes is high. While it is idle, both strobes are low.
- R10: `rd_valid` is high in exactly the cycles that follow a cycle with `rd_done` high. `rd_data` holds its last value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Producer access request |
| wr_sync | input | 1 | 1 = tag-conditioned write, 0 = raw write |
| wr_addr | input | 4 | Producer word address |
| wr_data | input | 32 | Word to store |
| wr_done | output | 1 | Write accepted this cycle |
| wr_retry | output | 1 | Write refused this cycle (word full) |
| rd_req | input | 1 | Consumer access request |
| rd_sync | input | 1 | 1 = tag-conditioned read, 0 = raw read |
| rd_addr | input | 4 | Consumer word address |
| rd_done | output | 1 | Read accepted this cycle |
| rd_retry | output | 1 | Read refused this cycle (word empty) |
| rd_valid | output | 1 | `rd_data` carries the word of last cycle's accepted read |
| rd_data | output | 32 | Read data, one cycle latency |

## Verification
The assertions check on every cycle that each port gives exactly one answer per request and that `rd_valid` follows `rd_done`. They also check the tag effect of each kind of access: accepted writes leave the word full, refused accesses keep the tag, synchronising reads empty it and raw reads preserve it. They also check that reset empties the tags. Only the bench scenarios can show that the data itself is right. This covers refused writes leaving the old word intact, the old value being returned when a word is drained and refilled in the same cycle, and long random mixes of raw and synchronising traffic matching a behavioural model.

// File: rtl/fe_pkg.sv
package fe_pkg;

    // Access mode carried by the wr_sync / rd_sync pins
    typedef enum logic {
        MODE_RAW  = 1'b0,
        MODE_SYNC = 1'b1
    } fe_mode_e;

    // Per-cycle decision produced by the tag controller
    typedef struct packed {
        logic rd_ok;     // read accepted
        logic rd_clear;  // accepted read empties its word
        logic wr_ok;     // write accepted
    } fe_grant_t;

endpackage

// File: rtl/fe_tag_ctrl.sv
module fe_tag_ctrl
    import fe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_sync,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_req,
    input  logic              rd_sync,
    input  logic [ADDR_W-1:0] rd_addr,
    output fe_grant_t         grant,
    output logic [DEPTH-1:0]  tags
);

    typedef struct packed {
        logic [DEPTH-1:0] tag;
    } tag_state_t;

    tag_state_t state_q, state_d;
    fe_grant_t  grant_d;

    logic rd_tag;
    logic wr_tag_seen;
    logic same_word;

    always_comb begin
        state_d   = state_q;
        grant_d   = '0;
        same_word = (rd_addr == wr_addr);
        rd_tag    = state_q.tag[rd_addr];

        // Read is resolved first against the registered tag
        grant_d.rd_ok    = rd_req && ((fe_mode_e'(rd_sync) == MODE_RAW) || rd_tag);
        grant_d.rd_clear = grant_d.rd_ok && (fe_mode_e'(rd_sync) == MODE_SYNC);

        // Write sees the tag as left by the read in the same cycle
        wr_tag_seen   = (grant_d.rd_clear && same_word) ? 1'b0 : state_q.tag[wr_addr];
        grant_d.wr_ok = wr_req && ((fe_mode_e'(wr_sync) == MODE_RAW) || !wr_tag_seen);

        if (grant_d.rd_clear) begin
            state_d.tag[rd_addr] = 1'b0;
        end
        if (grant_d.wr_ok) begin
            state_d.tag[wr_addr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant = grant_d;
    assign tags  = state_q.tag;

endmodule

// File: rtl/fe_data_store.sv
module fe_data_store #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [WIDTH-1:0]  rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] word;
        logic [WIDTH-1:0]            rd_data;
        logic                        rd_valid;
    } store_state_t;

    store_state_t state_q, state_d;
    logic [DEPTH-1:0] word_we;

    // One write strobe per word
    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign word_we[g] = wr_en && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = rd_en;
        // Read takes the pre-write contents of the word
        if (rd_en) begin
            state_d.rd_data = state_q.word[rd_addr];
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (word_we[i]) begin
                state_d.word[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_valid = state_q.rd_valid;
    assign rd_data  = state_q.rd_data;

endmodule

// File: rtl/fe_word_mem.sv
module fe_word_mem
    import fe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_sync,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic              wr_done,
    output logic              wr_retry,
    input  logic              rd_req,
    input  logic              rd_sync,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_done,
    output logic              rd_retry,
    output logic              rd_valid,
    output logic [WIDTH-1:0]  rd_data
);

    fe_grant_t        grant;
    logic [DEPTH-1:0] tag_vec;

    fe_tag_ctrl #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) i_tag_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wr_sync (wr_sync),
        .wr_addr (wr_addr),
        .rd_req  (rd_req),
        .rd_sync (rd_sync),
        .rd_addr (rd_addr),
        .grant   (grant),
        .tags    (tag_vec)
    );

    fe_data_store #(
        .DEPTH  (DEPTH),
        .WIDTH  (WIDTH),
        .ADDR_W (ADDR_W)
    ) i_data_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (grant.wr_ok),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (grant.rd_ok),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign wr_done  = grant.wr_ok;
    assign wr_retry = wr_req && !grant.wr_ok;
    assign rd_done  = grant.rd_ok;
    assign rd_retry = rd_req && !grant.rd_ok;

endmodule

// File: rtl/fe_word_mem_checker.sv
module fe_word_mem_checker #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic              wr_sync,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_done,
    input logic              wr_retry,
    input logic              rd_req,
    input logic              rd_sync,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_done,
    input logic              rd_retry,
    input logic              rd_valid,
    input logic [DEPTH-1:0]  tag_vec
);

    logic wr_hits_rd;
    assign wr_hits_rd = wr_done && (wr_addr == rd_addr);

    p_wr_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_done ^ wr_retry));
    p_wr_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> (!wr_done && !wr_retry));
    p_rd_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_done ^ rd_retry));
    p_rd_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (!rd_done && !rd_retry));

    p_valid_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> rd_valid);
    p_no_valid_without_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> !rd_valid);

    // R1 and R2: any accepted write leaves its word full
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> tag_vec[$past(wr_addr)]);

    p_write_refused_keeps_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_retry |=> tag_vec[$past(wr_addr)]);

    p_sync_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_sync && !wr_hits_rd) |=> !tag_vec[$past(rd_addr)]);

    p_read_refused_keeps_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_retry && !wr_hits_rd) |=> !tag_vec[$past(rd_addr)]);

    p_raw_read_keeps_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_sync && !wr_hits_rd) |=> (tag_vec[$past(rd_addr)] == $past(tag_vec[rd_addr])));

    p_refill_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_sync && wr_req && wr_sync && (wr_addr == rd_addr)) |-> wr_done);

    p_reset_empties_r8: assert property (@(posedge clk)
        !rst_n |-> (tag_vec == '0 && !rd_valid));

endmodule

bind fe_word_mem fe_word_mem_checker #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_sync  (wr_sync),
    .wr_addr  (wr_addr),
    .wr_done  (wr_done),
    .wr_retry (wr_retry),
    .rd_req   (rd_req),
    .rd_sync  (rd_sync),
    .rd_addr  (rd_addr),
    .rd_done  (rd_done),
    .rd_retry (rd_retry),
    .rd_valid (rd_valid),
    .tag_vec  (tag_vec)
);

// File: tb/test_fe_word_mem.sv
`timescale 1ns/1ps
module test_fe_word_mem;

    localparam int DEPTH  = 16;
    localparam int WIDTH  = 32;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_req = 1'b0, wr_sync = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WIDTH-1:0]  wr_data = '0;
    logic              wr_done, wr_retry;
    logic              rd_req = 1'b0, rd_sync = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_done, rd_retry, rd_valid;
    logic [WIDTH-1:0]  rd_data;

    always #2 clk = ~clk;

    fe_word_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_fe_word_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_sync(wr_sync), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_done(wr_done), .wr_retry(wr_retry),
        .rd_req(rd_req), .rd_sync(rd_sync), .rd_addr(rd_addr),
        .rd_done(rd_done), .rd_retry(rd_retry), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Behavioural reference
    logic [WIDTH-1:0] ref_mem [DEPTH];
    bit               ref_full [DEPTH];
    bit               exp_valid = 0;
    logic [WIDTH-1:0] exp_data = '0;
    string            prev_tag = "R8";

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    task automatic check(string req, string what, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access cycle: check last cycle's read output, drive, check answers, update model
    task automatic step(string req, bit wq, bit ws, int wa, logic [WIDTH-1:0] wd,
                        bit rq, bit rs, int ra);
        bit rok, wok, wtag;
        @(negedge clk);
        check(prev_tag, "rd_valid", WIDTH'(rd_valid), WIDTH'(exp_valid));
        if (exp_valid) check(prev_tag, "rd_data", rd_data, exp_data);
        wr_req = wq; wr_sync = ws; wr_addr = ADDR_W'(wa); wr_data = wd;
        rd_req = rq; rd_sync = rs; rd_addr = ADDR_W'(ra);
        #1;
        rok  = rq && (!rs || ref_full[ra]);
        wtag = (rok && rs && ra == wa) ? 1'b0 : ref_full[wa];
        wok  = wq && (!ws || !wtag);
        check(req, "wr_done",  WIDTH'(wr_done),  WIDTH'(wok));
        check(req, "wr_retry", WIDTH'(wr_retry), WIDTH'(wq && !wok));
        check(req, "rd_done",  WIDTH'(rd_done),  WIDTH'(rok));
        check(req, "rd_retry", WIDTH'(rd_retry), WIDTH'(rq && !rok));
        exp_valid = rok;
        if (rok) begin
            exp_data = ref_mem[ra];
            if (rs) ref_full[ra] = 0;
        end
        if (wok) begin
            ref_mem[wa]  = wd;
            ref_full[wa] = 1;
        end
        prev_tag = req;
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, '0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '0;
            ref_full[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "rd_valid in reset", WIDTH'(rd_valid), '0);
        rst_n = 1'b1;

        // R8: every word starts empty, so synchronising reads retry
        for (int i = 0; i < DEPTH; i++) step("R8", 0, 0, 0, '0, 1, 1, i);

        // R1: raw write fills words, also one already full
        step("R1", 1, 0, 3, 32'hA5A5_0003, 0, 0, 0);
        step("R1", 1, 0, 3, 32'h1234_5678, 0, 0, 0);
        // R2: synchronising writes into empty words
        step("R2", 1, 1, 5, 32'hCAFE_0005, 0, 0, 0);
        step("R2", 1, 1, 15, 32'hFFFF_000F, 0, 0, 0);
        // R3: write to a full word is refused; data kept (seen through raw read)
        step("R3", 1, 1, 5, 32'hDEAD_BEEF, 0, 0, 0);
        step("R3", 0, 0, 0, '0, 1, 0, 5);
        idle("R3");
        // R7: raw read of full and empty words leaves tags alone
        step("R7", 0, 0, 0, '0, 1, 0, 3);
        step("R7", 0, 0, 0, '0, 1, 0, 9);
        step("R7", 0, 0, 0, '0, 1, 1, 3);   // still full after raw read
        // R4: synchronising read drains, then retries
        step("R4", 0, 0, 0, '0, 1, 1, 15);
        step("R5", 0, 0, 0, '0, 1, 1, 15);
        step("R5", 0, 0, 0, '0, 1, 1, 0);
        // R6: drain and refill word 5 in one cycle, then read new value
        step("R6", 1, 1, 5, 32'h0BAD_F00D, 1, 1, 5);
        step("R6", 0, 0, 0, '0, 1, 1, 5);
        // R6: empty word, read retries and write fills
        step("R6", 1, 1, 7, 32'h7777_7777, 1, 1, 7);
        step("R6", 1, 0, 7, 32'h8888_8888, 1, 1, 7);
        step("R6", 0, 0, 0, '0, 1, 1, 7);
        // R10: back-to-back reads, then idle
        step("R10", 1, 0, 1, 32'h1111_1111, 1, 0, 3);
        step("R10", 0, 0, 0, '0, 1, 0, 1);
        idle("R10");
        idle("R10");

        // R9: random mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            step("R9", 1'($urandom), 1'($urandom % 4 != 0), int'($urandom % 4),
                 $urandom, 1'($urandom), 1'($urandom % 4 != 0), int'($urandom % 4));
        end
        idle("R9");

        // R8: reset mid-run empties the words again
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8", "rd_valid after reset", WIDTH'(rd_valid), '0);
        for (int i = 0; i < DEPTH; i++) ref_full[i] = 0;
        exp_valid = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step("R8", 0, 0, 0, '0, 1, 1, 3);
        step("R8", 1, 1, 3, 32'h3333_3333, 0, 0, 0);
        idle("R8");

        finish_run();
    end

endmodule